// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and a calendar as a chain of packed BCD digit counters. A one-cycle `tick` input, produced by an external prescaler once per second, advances the seconds. Carries ripple from seconds through minutes and hours to the date, month, two-digit year and day of week in the same clock cycle. Hours count in either 12-hour form, with a PM flag held in the hour-tens nibble, or 24-hour form, as selected by `mode_24h`.

The host sees every digit as a 4-bit nibble at its own address. It can overwrite any nibble through a single-cycle write port and read any nibble through a registered read port. Values the host writes are not range-checked. A date that cannot exist, such as the 31st of a 30-day month or the 29th of February in a common year, is kept as written and becomes the 1st of the next month at the next day carry. Leap years are taken from the two-digit year. The block also emits three registered strobes, one each for the second, minute and hour events, which a periodic-interrupt generator can use.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After synchronous reset with `mode_24h`=0, the time reads 12:00:00 AM (hour ones 2, hour tens 1). With `mode_24h`=1 it reads 00:00:00. In both cases the date reads day 01, month 01, year 00, weekday 0, and all three strobes are low.
- R2: Seconds and minutes each count 00..59 in BCD. Ones count 0..9 and tens count 0..5. When seconds pass 59 they become 00 and the minutes advance. When minutes pass 59 they become 00 and the hours advance.
- R3: `sec_stb` is high for exactly the cycle after each `tick`. `min_stb` is high in that cycle only when the seconds wrapped. `hr_stb` is high only when both seconds and minutes wrapped. `hr_stb` implies `min_stb`, and `min_stb` implies `sec_stb`.
- R4: With `mode_24h`=1, hours count 00..23. Passing 23 gives 00 and advances the date by one day.
- R5: With `mode_24h`=0, each half day counts 12, 01, ..., 11. The PM flag (bit 2 of the hour-tens nibble, 1 = PM) toggles on the step from 11 to 12. The step from 11 PM to 12 AM advances the date by one day. Bits 1..0 of the hour-tens nibble hold the tens of hours.
- R6: With `mode_24h`=1, the PM flag reads back as 0 and has no effect on counting.
- R7: The address map is: 0 seconds ones, 1 seconds tens, 2 minutes ones, 3 minutes tens, 4 hour ones, 5 hour tens, 6 date ones, 7 date tens, 8 month ones, 9 month tens, 10 year ones, 11 year tens, 12 weekday. Bits that have no use are stored and read as 0: bit 3 of addresses 1, 3, 5 and 12; bits 3..2 of address 7; bits 3..1 of address 9. Addresses 13..15 always read 0, and writes to them change nothing.
- R8: The date steps through 1..N in BCD. N is 31, 30 (April, June, September, November), 29 (February when the year is divisible by 4, with year 00 counted as a leap year) or 28 (other Februaries). A day carry from day N gives the 1st of the next month.
- R9: A day carry from a stored day greater than the month length gives the 1st of the following month.
- R10: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R11: The weekday (0 = Sunday) advances on every day carry and wraps from 6 to 0.
- R12: `rd_data` shows the nibble at `rd_addr` one clock after the address is applied. A write in the same cycle as a `tick` replaces only the addressed nibble. All other digits advance as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable, once per second |
| mode_24h | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour |
| wr_en | input | 1 | Write strobe for one nibble |
| wr_addr | input | 4 | Nibble address for writes |
| wr_data | input | 4 | Write data |
| rd_addr | input | 4 | Nibble address for reads |
| rd_data | output | 4 | Registered read data |
| sec_stb | output | 1 | Second event strobe |
| min_stb | output | 1 | Minute event strobe |
| hr_stb | output | 1 | Hour event strobe |

## Verification
A wrong carry decision shows up at the read port as a digit that is one count off after the first tick that crosses the faulty boundary. A wrong decision in the hour or date logic is visible after a single tick from 23:59:59 or 11:59:59 PM. For this reason the bench loads the state just before each boundary and then ticks once. This applies to every hour in both modes, every month end, and February of all hundred years. A fault in the strobe chain appears on the strobe outputs one cycle after the offending tick. A fault in read masking appears on the next read of the affected address.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NIB_W      = 4;
  localparam int ADDR_W     = 4;
  localparam int NUM_DIGITS = 13;
  localparam int VAL_W      = 8;

  localparam logic [ADDR_W-1:0] A_SEC1  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC10 = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN1  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MIN10 = 4'd3;
  localparam logic [ADDR_W-1:0] A_HR1   = 4'd4;
  localparam logic [ADDR_W-1:0] A_HR10  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DAY1  = 4'd6;
  localparam logic [ADDR_W-1:0] A_DAY10 = 4'd7;
  localparam logic [ADDR_W-1:0] A_MON1  = 4'd8;
  localparam logic [ADDR_W-1:0] A_MON10 = 4'd9;
  localparam logic [ADDR_W-1:0] A_YR1   = 4'd10;
  localparam logic [ADDR_W-1:0] A_YR10  = 4'd11;
  localparam logic [ADDR_W-1:0] A_WDAY  = 4'd12;

  localparam logic [NIB_W-1:0] M_TENS60 = 4'h7;
  localparam logic [NIB_W-1:0] M_HR10   = 4'h7;
  localparam logic [NIB_W-1:0] M_DAY10  = 4'h3;
  localparam logic [NIB_W-1:0] M_MON10  = 4'h1;
  localparam logic [NIB_W-1:0] M_WDAY   = 4'h7;

  typedef logic [NIB_W-1:0] nib_t;
  typedef struct packed {
    nib_t tens;
    nib_t ones;
  } bcd2_t;

  function automatic logic [VAL_W-1:0] bcd_val(nib_t t, nib_t o);
    return {4'b0, t} * 8'd10 + {4'b0, o};
  endfunction

  function automatic bcd2_t bcd_inc(bcd2_t v);
    bcd2_t r;
    if (v.ones >= 4'd9) begin
      r.ones = 4'd0;
      r.tens = v.tens + 4'd1;
    end else begin
      r.ones = v.ones + 4'd1;
      r.tens = v.tens;
    end
    return r;
  endfunction

  function automatic logic leap_year(nib_t t, nib_t o);
    if (t[0]) return (o == 4'd2) || (o == 4'd6);
    return (o == 4'd0) || (o == 4'd4) || (o == 4'd8);
  endfunction

  function automatic logic [VAL_W-1:0] month_days(logic [VAL_W-1:0] m, logic leap);
    case (m)
      8'd2:                     return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_mod60.sv
module cal_mod60
  import cal_pkg::*;
#(
  parameter int ONES_LAST = 9,
  parameter int TENS_LAST = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic wr_ones,
  input  logic wr_tens,
  input  nib_t wr_data,
  output nib_t ones,
  output nib_t tens,
  output logic wrap
);
  localparam nib_t OL = nib_t'(ONES_LAST);
  localparam nib_t TL = nib_t'(TENS_LAST);

  logic ones_last;
  logic tens_last;

  assign ones_last = (ones >= OL);
  assign tens_last = (tens >= TL);
  assign wrap      = step && ones_last && tens_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones <= '0;
      tens <= '0;
    end else begin
      if (wr_ones)
        ones <= wr_data;
      else if (step)
        ones <= ones_last ? 4'd0 : ones + 4'd1;

      if (wr_tens)
        tens <= wr_data & M_TENS60;
      else if (step && ones_last)
        tens <= tens_last ? 4'd0 : tens + 4'd1;
    end
  end
endmodule

// File: rtl/cal_hour_ctr.sv
module cal_hour_ctr
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_24h,
  input  logic step,
  input  logic wr_ones,
  input  logic wr_tens,
  input  nib_t wr_data,
  output nib_t ones,
  output nib_t tens,
  output logic day_step
);
  logic [1:0] t;
  logic       pm;
  nib_t       n_ones;
  nib_t       n_tens;
  logic       carry;

  assign t  = tens[1:0];
  assign pm = tens[2];

  always_comb begin
    n_ones = ones;
    n_tens = tens;
    carry  = 1'b0;
    if (mode_24h) begin
      if (t == 2'd2 && ones >= 4'd3) begin
        n_ones = 4'd0;
        n_tens = {1'b0, pm, 2'b00};
        carry  = 1'b1;
      end else if (ones >= 4'd9) begin
        n_ones = 4'd0;
        n_tens = {1'b0, pm, 2'(t + 2'd1)};
      end else begin
        n_ones = ones + 4'd1;
      end
    end else begin
      if (t == 2'd1 && ones == 4'd1) begin
        n_ones = 4'd2;
        n_tens = {1'b0, ~pm, 2'b01};
        carry  = pm;
      end else if (t == 2'd1 && ones >= 4'd2) begin
        n_ones = 4'd1;
        n_tens = {1'b0, pm, 2'b00};
      end else if (ones >= 4'd9) begin
        n_ones = 4'd0;
        n_tens = {1'b0, pm, 2'(t + 2'd1)};
      end else begin
        n_ones = ones + 4'd1;
      end
    end
  end

  assign day_step = step && carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones <= mode_24h ? 4'd0 : 4'd2;
      tens <= mode_24h ? 4'd0 : 4'd1;
    end else begin
      if (wr_ones)
        ones <= wr_data;
      else if (step)
        ones <= n_ones;

      if (wr_tens)
        tens <= wr_data & M_HR10;
      else if (step)
        tens <= n_tens;
    end
  end
endmodule

// File: rtl/cal_date_ctr.sv
module cal_date_ctr
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic [6:0] wr_sel,
  input  nib_t       wr_data,
  output nib_t       day1,
  output nib_t       day10,
  output nib_t       mon1,
  output nib_t       mon10,
  output nib_t       yr1,
  output nib_t       yr10,
  output nib_t       wday
);
  logic [VAL_W-1:0] dval;
  logic [VAL_W-1:0] mval;
  logic [VAL_W-1:0] dim;
  logic             leap;
  logic             last_day;
  logic             last_mon;
  bcd2_t            day_n;
  bcd2_t            mon_n;
  bcd2_t            yr_n;

  always_comb begin
    dval     = bcd_val(day10, day1);
    mval     = bcd_val(mon10, mon1);
    leap     = leap_year(yr10, yr1);
    dim      = month_days(mval, leap);
    last_day = (dval >= dim);
    last_mon = (mval >= 8'd12);

    day_n = bcd_inc('{tens: day10, ones: day1});
    mon_n = bcd_inc('{tens: mon10, ones: mon1});
    yr_n  = bcd_inc('{tens: yr10, ones: yr1});
    if (yr_n.tens > 4'd9) yr_n.tens = 4'd0;

    if (last_day) day_n = '{tens: 4'd0, ones: 4'd1};
    if (last_mon) mon_n = '{tens: 4'd0, ones: 4'd1};
    if (!(last_day && last_mon)) yr_n = '{tens: yr10, ones: yr1};
    if (!last_day) mon_n = '{tens: mon10, ones: mon1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      day1  <= 4'd1;
      day10 <= 4'd0;
      mon1  <= 4'd1;
      mon10 <= 4'd0;
      yr1   <= 4'd0;
      yr10  <= 4'd0;
      wday  <= 4'd0;
    end else begin
      if (wr_sel[0])      day1  <= wr_data;
      else if (step)      day1  <= day_n.ones;
      if (wr_sel[1])      day10 <= wr_data & M_DAY10;
      else if (step)      day10 <= day_n.tens & M_DAY10;
      if (wr_sel[2])      mon1  <= wr_data;
      else if (step)      mon1  <= mon_n.ones;
      if (wr_sel[3])      mon10 <= wr_data & M_MON10;
      else if (step)      mon10 <= mon_n.tens & M_MON10;
      if (wr_sel[4])      yr1   <= wr_data;
      else if (step)      yr1   <= yr_n.ones;
      if (wr_sel[5])      yr10  <= wr_data;
      else if (step)      yr10  <= yr_n.tens;
      if (wr_sel[6])      wday  <= wr_data & M_WDAY;
      else if (step)      wday  <= (wday >= 4'd6) ? 4'd0 : wday + 4'd1;
    end
  end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              mode_24h,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NIB_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NIB_W-1:0]  rd_data,
  output logic              sec_stb,
  output logic              min_stb,
  output logic              hr_stb
);
  localparam int MS_STAGES = 2;

  logic [NUM_DIGITS-1:0] wr_sel;
  logic [MS_STAGES:0]    stage_step;
  nib_t                  ms_ones [MS_STAGES];
  nib_t                  ms_tens [MS_STAGES];
  logic [MS_STAGES-1:0]  ms_wrap;
  nib_t                  sec_ones;
  nib_t                  sec_tens;
  nib_t                  hr_ones;
  nib_t                  hr_tens;
  logic                  day_step;
  nib_t                  day1, day10, mon1, mon10, yr1, yr10, wday;
  nib_t                  rd_mux;

  always_comb begin
    for (int i = 0; i < NUM_DIGITS; i++)
      wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  assign stage_step[0] = tick;

  for (genvar g = 0; g < MS_STAGES; g++) begin : g_ms
    cal_mod60 #(.ONES_LAST(9), .TENS_LAST(5)) u_ms (
      .clk     (clk),
      .rst     (rst),
      .step    (stage_step[g]),
      .wr_ones (wr_sel[2*g]),
      .wr_tens (wr_sel[2*g+1]),
      .wr_data (wr_data),
      .ones    (ms_ones[g]),
      .tens    (ms_tens[g]),
      .wrap    (ms_wrap[g])
    );
    assign stage_step[g+1] = ms_wrap[g];
  end

  assign sec_ones = ms_ones[0];
  assign sec_tens = ms_tens[0];

  cal_hour_ctr u_hour (
    .clk      (clk),
    .rst      (rst),
    .mode_24h (mode_24h),
    .step     (stage_step[MS_STAGES]),
    .wr_ones  (wr_sel[A_HR1]),
    .wr_tens  (wr_sel[A_HR10]),
    .wr_data  (wr_data),
    .ones     (hr_ones),
    .tens     (hr_tens),
    .day_step (day_step)
  );

  cal_date_ctr u_date (
    .clk     (clk),
    .rst     (rst),
    .step    (day_step),
    .wr_sel  (wr_sel[A_WDAY:A_DAY1]),
    .wr_data (wr_data),
    .day1    (day1),
    .day10   (day10),
    .mon1    (mon1),
    .mon10   (mon10),
    .yr1     (yr1),
    .yr10    (yr10),
    .wday    (wday)
  );

  always_comb begin
    case (rd_addr)
      A_SEC1:  rd_mux = ms_ones[0];
      A_SEC10: rd_mux = ms_tens[0];
      A_MIN1:  rd_mux = ms_ones[1];
      A_MIN10: rd_mux = ms_tens[1];
      A_HR1:   rd_mux = hr_ones;
      A_HR10:  rd_mux = mode_24h ? {2'b00, hr_tens[1:0]} : hr_tens;
      A_DAY1:  rd_mux = day1;
      A_DAY10: rd_mux = day10;
      A_MON1:  rd_mux = mon1;
      A_MON10: rd_mux = mon10;
      A_YR1:   rd_mux = yr1;
      A_YR10:  rd_mux = yr10;
      A_WDAY:  rd_mux = wday;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      sec_stb <= 1'b0;
      min_stb <= 1'b0;
      hr_stb  <= 1'b0;
    end else begin
      rd_data <= rd_mux;
      sec_stb <= stage_step[0];
      min_stb <= stage_step[1];
      hr_stb  <= stage_step[2];
    end
  end
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              mode_24h,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [NIB_W-1:0]  rd_data,
  input logic              sec_stb,
  input logic              min_stb,
  input logic              hr_stb,
  input nib_t              sec_ones,
  input nib_t              sec_tens
);
  // R3: second strobe follows each tick by one cycle
  p_sec_stb_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sec_stb == $past(tick)));

  // R3: strobes nest
  p_min_in_sec_r3: assert property (@(posedge clk) disable iff (rst)
    min_stb |-> sec_stb);
  p_hr_in_min_r3: assert property (@(posedge clk) disable iff (rst)
    hr_stb |-> min_stb);

  // R2: a minute event leaves the seconds at 00
  p_min_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (min_stb && !$past(wr_en) && !$past(rst)) |-> (sec_ones == 4'd0 && sec_tens == 4'd0));

  // R6: PM flag hidden in 24-hour mode
  p_pm_hidden_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_24h) && $past(rd_addr) == A_HR10) |-> (rd_data[3:2] == 2'b00));

  // R7: unmapped addresses read zero
  p_unmapped_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr) > A_WDAY) |-> (rd_data == 4'd0));
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .mode_24h (mode_24h),
  .wr_en    (wr_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .sec_stb  (sec_stb),
  .min_stb  (min_stb),
  .hr_stb   (hr_stb),
  .sec_ones (sec_ones),
  .sec_tens (sec_tens)
);

// File: tb/bcd_calendar_clock_test.sv
`timescale 1ns/1ps
module bcd_calendar_clock_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       mode_24h = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [3:0] wr_data = 4'd0;
  logic [3:0] rd_addr = 4'd0;
  logic [3:0] rd_data;
  logic       sec_stb, min_stb, hr_stb;

  int ntests = 0;
  int nfail  = 0;
  int s_st, m_st, h_st;

  always #4 clk = ~clk;

  bcd_calendar_clock uut (
    .clk(clk), .rst(rst), .tick(tick), .mode_24h(mode_24h),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_stb(sec_stb), .min_stb(min_stb), .hr_stb(hr_stb)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 4'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 4'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic rd2(input int a, output int v);
    int o, t;
    rd(a, o); rd(a + 1, t);
    v = t * 10 + o;
  endtask

  task automatic tk();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    s_st = int'(sec_stb); m_st = int'(min_stb); h_st = int'(hr_stb);
  endtask

  task automatic do_reset(input bit m24);
    rst = 1'b1; mode_24h = m24;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_date(input int d, input int m, input int y);
    wr(6, d % 10); wr(7, d / 10); wr(8, m % 10); wr(9, m / 10);
    wr(10, y % 10); wr(11, y / 10);
  endtask

  task automatic get_date(output int d, output int m, output int y);
    rd2(6, d); rd2(8, m); rd2(10, y);
  endtask

  task automatic eod24();
    wr(4, 3); wr(5, 2); wr(2, 9); wr(3, 5); wr(0, 9); wr(1, 5);
  endtask

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic date_step(input string req, input int d, input int m, input int y,
                           input int ed, input int em, input int ey);
    int ad, am, ay;
    set_date(d, m, y);
    eod24();
    tk();
    get_date(ad, am, ay);
    chk(req, "day", ad, ed);
    chk(req, "month", am, em);
    chk(req, "year", ay, ey);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int v, v2;
    @(negedge clk);

    // R1: reset state, 12-hour
    do_reset(1'b0);
    chk("R1", "sec_stb", int'(sec_stb), 0);
    chk("R1", "min_stb", int'(min_stb), 0);
    chk("R1", "hr_stb", int'(hr_stb), 0);
    rd2(0, v); chk("R1", "seconds", v, 0);
    rd2(2, v); chk("R1", "minutes", v, 0);
    rd(4, v);  chk("R1", "hour ones", v, 2);
    rd(5, v);  chk("R1", "hour tens", v, 1);
    rd2(6, v); chk("R1", "day", v, 1);
    rd2(8, v); chk("R1", "month", v, 1);
    rd2(10, v); chk("R1", "year", v, 0);
    rd(12, v); chk("R1", "weekday", v, 0);

    // R1: reset state, 24-hour
    do_reset(1'b1);
    rd2(4, v); chk("R1", "hour 24h", v, 0);

    // R2 R3: full hour of ticks
    for (int k = 1; k <= 3600; k++) begin
      tk();
      chk("R3", "sec_stb", s_st, 1);
      chk("R3", "min_stb", m_st, (k % 60 == 0) ? 1 : 0);
      chk("R3", "hr_stb", h_st, (k % 3600 == 0) ? 1 : 0);
      rd2(0, v); chk("R2", "seconds", v, k % 60);
      rd2(2, v); chk("R2", "minutes", v, (k / 60) % 60);
    end
    chk("R3", "sec_stb idle", int'(sec_stb), 0);
    rd2(4, v); chk("R2", "hour after 3600 ticks", v, 1);

    // R4: every 24-hour step
    for (int h = 0; h < 24; h++) begin
      set_date(10, 1, 20);
      wr(4, h % 10); wr(5, h / 10); wr(2, 9); wr(3, 5); wr(0, 9); wr(1, 5);
      tk();
      chk("R4", "hr_stb", h_st, 1);
      rd2(4, v); chk("R4", "hour", v, (h + 1) % 24);
      rd2(6, v); chk("R4", "day", v, (h == 23) ? 11 : 10);
    end

    // R5: every 12-hour step
    mode_24h = 1'b0;
    for (int i = 0; i < 24; i++) begin
      int h12, pm, j, eh, epm;
      h12 = (i % 12 == 0) ? 12 : i % 12;
      pm  = (i >= 12) ? 1 : 0;
      j   = (i + 1) % 24;
      eh  = (j % 12 == 0) ? 12 : j % 12;
      epm = (j >= 12) ? 1 : 0;
      set_date(10, 1, 20);
      wr(4, h12 % 10); wr(5, pm * 4 + h12 / 10); wr(2, 9); wr(3, 5); wr(0, 9); wr(1, 5);
      tk();
      rd(4, v);  chk("R5", "hour ones", v, eh % 10);
      rd(5, v2); chk("R5", "hour tens+pm", v2, epm * 4 + eh / 10);
      rd2(6, v); chk("R5", "day", v, (i == 23) ? 11 : 10);
    end

    // R6: PM flag hidden in 24-hour mode
    wr(5, 6); wr(4, 1);
    rd(5, v); chk("R5", "pm visible in 12h", v, 6);
    mode_24h = 1'b1;
    rd(5, v); chk("R6", "pm hidden in 24h", v, 2);
    wr(0, 9); wr(1, 5); wr(2, 9); wr(3, 5); wr(4, 9); wr(5, 5);
    tk();
    rd2(4, v); chk("R6", "pm ignored counting 19->20", v, 20);

    // R7: unused bits and unmapped addresses
    wr(1, 15); rd(1, v); chk("R7", "sec tens mask", v, 7);
    wr(3, 15); rd(3, v); chk("R7", "min tens mask", v, 7);
    wr(7, 15); rd(7, v); chk("R7", "day tens mask", v, 3);
    wr(9, 15); rd(9, v); chk("R7", "month tens mask", v, 1);
    wr(12, 15); rd(12, v); chk("R7", "weekday mask", v, 7);
    mode_24h = 1'b0;
    wr(5, 15); rd(5, v); chk("R7", "hour tens mask", v, 7);
    mode_24h = 1'b1;
    wr(0, 3); wr(13, 15); wr(14, 15); wr(15, 15);
    rd(13, v); chk("R7", "addr 13", v, 0);
    rd(14, v); chk("R7", "addr 14", v, 0);
    rd(15, v); chk("R7", "addr 15", v, 0);
    rd(0, v);  chk("R7", "write to 13..15 ignored", v, 3);

    // R8: February for all years
    for (int y = 0; y < 100; y++) begin
      if (y % 4 == 0) date_step("R8", 28, 2, y, 29, 2, y);
      else            date_step("R8", 28, 2, y, 1, 3, y);
    end
    // R8 R10: every month end in two years
    for (int yi = 0; yi < 2; yi++) begin
      int y;
      y = 23 + yi;
      for (int m = 1; m <= 12; m++) begin
        if (m < 12) date_step("R8", dim(m, y), m, y, 1, m + 1, y);
        else        date_step("R10", 31, 12, y, 1, 1, y + 1);
      end
    end
    date_step("R8", 9, 5, 41, 10, 5, 41);
    date_step("R8", 30, 1, 41, 31, 1, 41);
    date_step("R10", 31, 12, 99, 1, 1, 0);
    date_step("R10", 31, 12, 9, 1, 1, 10);

    // R9: impossible dates
    date_step("R9", 29, 2, 83, 1, 3, 83);
    date_step("R9", 30, 2, 84, 1, 3, 84);
    date_step("R9", 31, 11, 83, 1, 12, 83);
    date_step("R9", 31, 4, 50, 1, 5, 50);

    // R11: weekday wraps
    wr(12, 0);
    for (int i = 0; i < 14; i++) begin
      set_date(5, 3, 21);
      eod24();
      tk();
      rd(12, v); chk("R11", "weekday", v, (i + 1) % 7);
    end

    // R12: write in tick cycle only replaces its nibble
    wr(0, 5); wr(1, 0); wr(2, 0); wr(3, 0);
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 4'd3; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd2(0, v); chk("R12", "seconds advance", v, 6);
    rd(2, v);  chk("R12", "written minute", v, 3);
    rd_addr = 4'd2;
    @(negedge clk);
    rd_addr = 4'd0;
    #1;
    chk("R12", "read latency one cycle", int'(rd_data), 3);
    @(negedge clk);
    chk("R12", "read after address change", int'(rd_data), 6);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule